// File: doc/BRIEF.md
# Marker-Framed Serial Link Transmitter

This block turns 10-bit parallel words into a serial stream at one bit per clock. Every payload word rides in a 12-bit frame that opens with a fixed two-bit clock marker (a low bit, then a high bit), so a receiver can recover the word clock from the one rising edge the marker guarantees. Before payload is sent, the block spends a training phase sending a plain periodic square-like pattern with one rising edge per frame. A receiver locks its delay line to that pattern.

A mode output tells the receiver side which phase the line is in. When the receiver reports that it has lost lock, the transmitter finishes the frame it is sending and goes back to training. The training length is programmable, but it can never be shorter than a fixed floor. Payload comes either from a valid/ready word port, one word per frame, or from an internal 31-stage pseudo-random generator used for bit-error testing.

Top module: `marker_link_tx`

## Requirements
- R1: A synchronous active-high reset puts the block in training mode at frame bit 0. In the first cycle after reset, pathCtrl and wordReady are 0 and serOut is 0.
- R2: In training mode each 12-bit frame is sent as six 0 bits followed by six 1 bits, repeated without gaps.
- R3: pathCtrl is 0 in every cycle that carries a training bit and 1 in every cycle that carries a data-frame bit.
- R4: The effective training length is trainLen bits, or 720 bits if trainLen is below 720. Training ends at the first frame boundary at which at least that many training bits have been sent since training began or last restarted. The mode changes only at frame boundaries.
- R5: A data frame is sent as 0, 1, then payload bits D0 (word bit 0) through D9 (word bit 9), with the next frame following directly.
- R6: wordReady is high for exactly one cycle, during the last bit of the frame before each port-sourced data frame. The word on wordData is taken when wordValid and wordReady are both high, and it is sent in the next frame.
- R7: If wordValid is low when wordReady is high, the next data frame carries an all-zero payload.
- R8: A lolReq pulse during data mode lets the current frame finish. The next frame is a training frame, and the training count restarts from zero.
- R9: lolReq during training restarts the training count, so training continues for at least the effective length after the request.
- R10: With prbsEn high, each data frame carries the next 10 bits of a generator whose state is 31 bits, seeded all ones at reset. Each step computes new = state[30] XOR state[27], shifts the state left with new entering bit 0, and outputs new. The first bit generated for a word is D0.
- R11: With prbsEn high, wordReady stays 0 and wordData and wordValid have no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| trainLen | input | 16 | Requested training length in bits (floored at 720) |
| lolReq | input | 1 | Loss-of-lock request from the receiver |
| prbsEn | input | 1 | Select internal pseudo-random payload |
| wordValid | input | 1 | Payload word available on wordData |
| wordData | input | 10 | Payload word, bit 0 sent first |
| wordReady | output | 1 | Word accepted this cycle when wordValid is high |
| serOut | output | 1 | Serial line bit |
| pathCtrl | output | 1 | 0 during training, 1 during data frames |

## Verification
The bench aims at the edges of the training phase. A trainLen below the floor must still produce exactly 720 training bits. A length that is not a multiple of 12 must round up to the next frame (800 gives 804). A design that switched mid-frame or ignored the floor would shift the marker phase, and every later payload bit would miss the reference model. A loss-of-lock pulse in the middle of a data frame checks that the frame is not truncated. A pulse in the middle of training checks that the count restarts, so the run is longer than 1020 bits. Idle payload frames must carry zeros rather than a stale word. In pseudo-random mode the bench compares each payload against an independent model of the generator and watches for any stray wordReady.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  localparam int WORD_W     = 10;
  localparam int FRAME_BITS = WORD_W + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic             modeData;
    logic             loadWord;
    logic [IDX_W-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/mlt_prbs.sv
module mlt_prbs import mlt_pkg::*; #(
  parameter int LEN   = 31,
  parameter int TAP   = 28,
  parameter int OUT_W = WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [OUT_W-1:0] word
);
  logic [LEN-1:0] state;
  logic [LEN-1:0] stepState;

  // Unroll OUT_W generator steps; bit 0 of the word is the first new bit.
  always_comb begin
    stepState = state;
    word = '0;
    for (int i = 0; i < OUT_W; i++) begin
      word[i] = stepState[LEN-1] ^ stepState[TAP-1];
      stepState = {stepState[LEN-2:0], word[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= '1;
    else if (advance) state <= stepState;
  end

  AST_PRBS_NOT_STUCK: assert property (@(posedge clk) disable iff (rst)
    state != '0) else $error("generator state collapsed to zero"); // R10
endmodule

// File: rtl/mlt_ctrl.sv
module mlt_ctrl import mlt_pkg::*; #(
  parameter int TRAIN_W   = 16,
  parameter int MIN_TRAIN = 720
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TRAIN_W-1:0] trainLen,
  input  logic               lolReq,
  output strobe_t            strobe
);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [TRAIN_W-1:0] FLOOR    = TRAIN_W'(MIN_TRAIN);
  localparam logic [TRAIN_W-1:0] CNT_MAX  = '1;

  logic               modeData;
  logic               lolPend;
  logic [IDX_W-1:0]   bitCnt;
  logic [TRAIN_W-1:0] trainCnt;
  logic [TRAIN_W-1:0] cntNext;
  logic [TRAIN_W-1:0] effLen;
  logic               lastBit;
  logic               trainDone;
  logic               goData;

  always_comb begin
    effLen    = (trainLen < FLOOR) ? FLOOR : trainLen;
    cntNext   = (trainCnt == CNT_MAX) ? trainCnt : trainCnt + 1'b1;
    lastBit   = (bitCnt == LAST_IDX);
    trainDone = (cntNext >= effLen);
    goData    = modeData ? !(lolReq || lolPend) : (!lolReq && trainDone);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeData <= 1'b0;
      lolPend  <= 1'b0;
      bitCnt   <= '0;
      trainCnt <= '0;
    end else begin
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      if (!modeData) begin
        trainCnt <= lolReq ? '0 : cntNext;
        if (lastBit) modeData <= goData;
      end else begin
        if (lolReq) lolPend <= 1'b1;
        if (lastBit && !goData) begin
          modeData <= 1'b0;
          lolPend  <= 1'b0;
          trainCnt <= '0;
        end
      end
    end
  end

  assign strobe = '{modeData: modeData, loadWord: lastBit && goData, bitIdx: bitCnt};

  AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$stable(modeData) |-> $past(bitCnt) == LAST_IDX) else $error("mode changed mid-frame"); // R4
  AST_TRAIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    $rose(modeData) |-> $past(trainCnt) >= $past(effLen) - 1'b1) else $error("training too short"); // R4
  AST_LOL_EXIT: assert property (@(posedge clk) disable iff (rst)
    (modeData && lastBit && (lolReq || lolPend)) |=> !modeData) else $error("lock loss not honoured"); // R8
  AST_LOL_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!modeData && lolReq) |=> trainCnt == '0) else $error("training count not restarted"); // R9
endmodule

// File: rtl/mlt_datapath.sv
module mlt_datapath import mlt_pkg::*; #(
  parameter int PRBS_LEN = 31,
  parameter int PRBS_TAP = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic              prbsEn,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              wordReady,
  output logic              serOut
);
  logic [WORD_W-1:0] frameWord;
  logic [WORD_W-1:0] prbsWord;
  logic [WORD_W-1:0] nextWord;
  logic [IDX_W-1:0]  payIdx;
  logic              prbsAdv;

  assign wordReady = strobe.loadWord && !prbsEn;
  assign prbsAdv   = strobe.loadWord && prbsEn;

  mlt_prbs #(.LEN(PRBS_LEN), .TAP(PRBS_TAP), .OUT_W(WORD_W)) u_prbs (
    .clk     (clk),
    .rst     (rst),
    .advance (prbsAdv),
    .word    (prbsWord)
  );

  always_comb begin
    if (prbsEn)         nextWord = prbsWord;
    else if (wordValid) nextWord = wordData;
    else                nextWord = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) frameWord <= '0;
    else if (strobe.loadWord) frameWord <= nextWord;
  end

  assign payIdx = strobe.bitIdx - IDX_W'(2);

  always_comb begin
    if (!strobe.modeData)        serOut = (strobe.bitIdx >= IDX_W'(FRAME_BITS / 2));
    else if (strobe.bitIdx == 0) serOut = 1'b0;
    else if (strobe.bitIdx == 1) serOut = 1'b1;
    else                         serOut = frameWord[payIdx];
  end

  AST_TRAIN_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (!strobe.modeData && strobe.bitIdx < IDX_W'(FRAME_BITS / 2)) |-> !serOut) else $error("training low half"); // R2
  AST_MARKER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (strobe.modeData && strobe.bitIdx == 1) |-> serOut) else $error("marker rising bit missing"); // R5
  AST_WORD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (wordReady && wordValid) |=> frameWord == $past(wordData)) else $error("word not captured"); // R6
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadWord && !prbsEn && !wordValid) |=> frameWord == '0) else $error("idle frame not zero"); // R7
endmodule

// File: rtl/marker_link_tx.sv
module marker_link_tx import mlt_pkg::*; #(
  parameter int TRAIN_W   = 16,
  parameter int MIN_TRAIN = 720,
  parameter int PRBS_LEN  = 31,
  parameter int PRBS_TAP  = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TRAIN_W-1:0] trainLen,
  input  logic               lolReq,
  input  logic               prbsEn,
  input  logic               wordValid,
  input  logic [WORD_W-1:0]  wordData,
  output logic               wordReady,
  output logic               serOut,
  output logic               pathCtrl
);
  strobe_t strobe;

  mlt_ctrl #(.TRAIN_W(TRAIN_W), .MIN_TRAIN(MIN_TRAIN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .trainLen (trainLen),
    .lolReq   (lolReq),
    .strobe   (strobe)
  );

  mlt_datapath #(.PRBS_LEN(PRBS_LEN), .PRBS_TAP(PRBS_TAP)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .prbsEn    (prbsEn),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordReady (wordReady),
    .serOut    (serOut)
  );

  assign pathCtrl = strobe.modeData;

  AST_READY_IN_DATA_PATH: assert property (@(posedge clk) disable iff (rst)
    wordReady |=> pathCtrl) else $error("ready not followed by data frame"); // R6
endmodule

// File: tb/marker_link_tx_tb.sv
module marker_link_tx_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [15:0] trainLen;
  logic       lolReq, prbsEn, wordValid;
  logic [9:0] wordData = 10'h2A5;
  logic       wordReady, serOut, pathCtrl;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  marker_link_tx u_dut (
    .clk(clk), .rst(rst), .trainLen(trainLen), .lolReq(lolReq), .prbsEn(prbsEn),
    .wordValid(wordValid), .wordData(wordData), .wordReady(wordReady),
    .serOut(serOut), .pathCtrl(pathCtrl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, compared every cycle.
  bit mMode, mPend, takeFlag = 1'b0;
  int mBit, mCnt;
  logic [9:0] mWord;
  logic [30:0] mPrbs;
  logic [9:0] expQ[$];

  always @(negedge clk) begin
    bit expSer, expRdy, lastB, goD;
    int eff;
    logic [9:0] w;
    if (rst) begin
      mMode = 0; mPend = 0; mBit = 0; mCnt = 0; mWord = '0; mPrbs = '1;
    end else begin
      eff = (trainLen < 720) ? 720 : int'(trainLen);
      if (!mMode) expSer = (mBit >= 6);
      else if (mBit == 0) expSer = 0;
      else if (mBit == 1) expSer = 1;
      else expSer = mWord[mBit-2];
      lastB = (mBit == 11);
      if (mMode) goD = !(lolReq || mPend);
      else goD = !lolReq && (((mCnt + 1 > 65535) ? 65535 : mCnt + 1) >= eff);
      expRdy = lastB && goD && !prbsEn;
      chk(pathCtrl == mMode, "R3 pathCtrl", pathCtrl, mMode);
      chk(serOut == expSer, mMode ? "R5 data bit" : "R2 training bit", serOut, expSer);
      chk(wordReady == expRdy, prbsEn ? "R11 wordReady" : "R6 wordReady", wordReady, expRdy);
      if (lastB && goD) begin
        if (prbsEn) begin
          for (int i = 0; i < 10; i++) begin
            w[i] = mPrbs[30] ^ mPrbs[27];
            mPrbs = {mPrbs[29:0], w[i]};
          end
        end else begin
          w = wordValid ? wordData : 10'd0;
          if (wordValid) takeFlag = 1'b1;
        end
        mWord = w;
        expQ.push_back(w);
      end
      if (!mMode) begin
        mCnt = lolReq ? 0 : ((mCnt + 1 > 65535) ? 65535 : mCnt + 1);
        if (lastB) mMode = goD;
      end else begin
        if (lolReq) mPend = 1;
        if (lastB && !goD) begin mMode = 0; mPend = 0; mCnt = 0; end
      end
      mBit = lastB ? 0 : mBit + 1;
    end
  end

  // New payload word after each accepted one.
  always @(posedge clk) begin
    #1;
    if (takeFlag) begin
      wordData = wordData * 10'd5 + 10'd3;
      takeFlag = 1'b0;
    end
  end

  // Line monitor: deserialises frames and measures training runs.
  int rxPos = 0, trainRun = 0, lastRun = 0, runs = 0, prbsReady = 0;
  bit prevPath = 1'b0;
  logic [9:0] rxWord;
  always @(negedge clk) begin
    logic [9:0] e;
    if (rst) begin
      rxPos = 0; trainRun = 0; prevPath = 0;
    end else begin
      if (prbsEn && wordReady) prbsReady++;
      if (!pathCtrl) begin
        trainRun++; rxPos = 0;
      end else begin
        if (!prevPath) begin lastRun = trainRun; runs++; trainRun = 0; end
        if (rxPos == 0) chk(serOut == 1'b0, "R5 marker low", serOut, 0);
        else if (rxPos == 1) chk(serOut == 1'b1, "R5 marker high", serOut, 1);
        else rxWord[rxPos-2] = serOut;
        if (rxPos == 11) begin
          if (expQ.size() == 0) chk(1'b0, "R6 unexpected frame", rxWord, 0);
          else begin
            e = expQ.pop_front();
            chk(rxWord == e, prbsEn ? "R10 payload" : (e == 0 ? "R7 payload" : "R6 payload"), rxWord, e);
          end
          rxPos = 0;
        end else rxPos++;
      end
      prevPath = pathCtrl;
    end
  end

  initial begin
    rst = 1; trainLen = 16'd100; lolReq = 0; prbsEn = 0; wordValid = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(pathCtrl == 0, "R1 pathCtrl after reset", pathCtrl, 0);
    chk(serOut == 0, "R1 serOut after reset", serOut, 0);
    chk(wordReady == 0, "R1 wordReady after reset", wordReady, 0);
    while (runs < 1) @(negedge clk);
    chk(lastRun == 720, "R4 floor training length", lastRun, 720);
    chk(pathCtrl == 1, "R3 data mode entered", pathCtrl, 1);
    repeat (60) @(posedge clk);
    #1 wordValid = 0;
    repeat (36) @(posedge clk);
    #1 wordValid = 1; trainLen = 16'd800;
    repeat (17) @(posedge clk);
    #1 lolReq = 1;
    @(posedge clk);
    #1 lolReq = 0;
    @(negedge clk);
    chk(pathCtrl == 1, "R8 frame finishes after request", pathCtrl, 1);
    while (runs < 2) @(negedge clk);
    chk(lastRun == 804, "R8 retrain rounds up to frame", lastRun, 804);
    repeat (40) @(posedge clk);
    #1 lolReq = 1; trainLen = 16'd100;
    @(posedge clk);
    #1 lolReq = 0;
    while (pathCtrl) @(negedge clk);
    repeat (300) @(posedge clk);
    #1 lolReq = 1;
    @(posedge clk);
    #1 lolReq = 0;
    while (runs < 3) @(negedge clk);
    chk(lastRun >= 1020 && lastRun % 12 == 0, "R9 training restarted", lastRun, 1020);
    repeat (5) @(posedge clk);
    #1 prbsEn = 1;
    repeat (130) @(posedge clk);
    #1;
    chk(prbsReady == 0, "R11 no ready in generator mode", prbsReady, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule